// File: doc/BRIEF.md
# I/O strobe ready stretcher

This block lengthens a processor's I/O bus cycle by a fixed number of clock periods. Slow peripherals can then be reached without changing the processor's software wait-state setting. The processor drives an active-low I/O strobe, and the block returns a READY line. READY drops in the same instant the strobe goes active. It rises again after a counted delay and stays high until the strobe is released.

The strobe is brought into the local clock domain through a two-flop synchroniser. A small synchronous counter measures the delay. It is held cleared while the synchronised strobe is idle and stops at the terminal count. READY is the OR of the raw strobe with the terminal-count flag. The path from the strobe falling to READY falling therefore stays combinational. Between two strobes the strobe must stay idle for at least three rising clock edges, so that the counter is cleared before the next cycle.

Top module: `io_ready_stretch`

## Requirements
- R1: While strobe_n is high, ready is high.
- R2: When strobe_n goes low, ready goes low in the same cycle, before any clock edge.
- R3: With strobe_n held low, ready stays low through STRETCH+1 rising clock edges and goes high after the (STRETCH+2)-th rising edge that follows the fall. Two of these edges are synchroniser latency and STRETCH are counted. With the default STRETCH of 4, ready rises after the 6th edge.
- R4: Once ready has risen, the counter stops, and ready stays high for as long as strobe_n remains low.
- R5: When strobe_n returns high, ready is high at once. A new strobe that follows at least 3 idle rising edges again gets the full delay of R3.
- R6: A strobe released before the terminal count leaves no residue. The next strobe that follows at least 3 idle rising edges gets the full delay of R3.
- R7: Asynchronous active-low reset clears the counter and sets the synchroniser to idle. While in reset, ready equals strobe_n. If strobe_n is held low across the release of reset, ready rises after the (STRETCH+2)-th rising edge that follows the release.
- R8: The counter never exceeds STRETCH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running counting clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| strobe_n | input | 1 | Processor I/O strobe, active low |
| ready | output | 1 | Bus ready; low holds off the I/O cycle |

## Verification
Two events can fall in the same cycle: the counter reaching its terminal count, and the processor releasing the strobe. Both try to raise ready at that moment. The bench provokes this by releasing the strobe just after the rising edge on which ready rises. It then checks that ready stays high through the idle gap and that the next strobe receives the full delay, not a shortened one. A reset that lands in the middle of a stretch, with the strobe still held low, is judged the same way: the delay must restart from the release of reset.

// File: rtl/io_ready_stretch.sv
module io_ready_stretch #(
  parameter int STRETCH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_n,
  output logic ready
);
  localparam int CW = $clog2(STRETCH + 1);
  localparam logic [CW-1:0] TERM = CW'(STRETCH);

  logic [1:0]    strb_q;
  logic [CW-1:0] cnt;
  logic          term;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) strb_q <= 2'b11;
    else        strb_q <= {strb_q[0], strobe_n};

  assign term = (cnt == TERM);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         cnt <= '0;
    else if (strb_q[1]) cnt <= '0;
    else if (!term)     cnt <= cnt + 1'b1;

  assign ready = strobe_n | term;
endmodule

module io_ready_stretch_chk #(
  parameter int STRETCH = 4,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          strobe_n,
  input logic          ready,
  input logic [1:0]    strb_q,
  input logic [CW-1:0] cnt
);
  // R1
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_n |-> ready);

  // R3
  early_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_n && int'(cnt) < STRETCH) |-> !ready);

  // R3
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb_q[1] && int'(cnt) < STRETCH) |=> (int'(cnt) == int'($past(cnt)) + 1));

  // R4
  hold_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb_q[1] && int'(cnt) == STRETCH) |=> (int'(cnt) == STRETCH));

  // R5
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb_q[1] |=> (cnt == '0));

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) <= STRETCH);
endmodule

bind io_ready_stretch io_ready_stretch_chk #(.STRETCH(STRETCH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .strobe_n(strobe_n), .ready(ready),
  .strb_q(strb_q), .cnt(cnt)
);

// File: tb/test_io_ready_stretch.sv
module test_io_ready_stretch;
  localparam int STRETCH = 4;
  localparam int RISE = STRETCH + 2;
  localparam int NV = 8;
  // {edges held low, idle edges after release}
  localparam int VEC [0:NV-1][0:1] = '{
    '{8, 3}, '{RISE, 3}, '{3, 3}, '{RISE + 1, 4},
    '{20, 3}, '{1, 3}, '{RISE - 1, 5}, '{RISE, 3}
  };

  logic clk = 0;
  logic rst_n = 0;
  logic strobe_n = 1;
  logic ready;
  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  io_ready_stretch #(.STRETCH(STRETCH)) i_io_ready_stretch (
    .clk(clk), .rst_n(rst_n), .strobe_n(strobe_n), .ready(ready)
  );

  task automatic check(input string req, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: ready=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_strobe(input int low_len, input int idle_len);
    @(negedge clk);
    strobe_n = 0;
    #1 check("R2", ready, 1'b0);
    for (int k = 1; k <= low_len; k++) begin
      @(posedge clk);
      #2 check(k >= RISE ? (k > RISE ? "R4" : "R3") : "R3", ready, k >= RISE);
    end
    @(negedge clk);
    strobe_n = 1;
    #1 check("R5", ready, 1'b1);
    for (int k = 1; k <= idle_len; k++) begin
      @(posedge clk);
      #2 check("R1", ready, 1'b1);
    end
  endtask

  initial begin
    #1 check("R7", ready, 1'b1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    repeat (2) @(posedge clk);
    #2 check("R1", ready, 1'b1);

    // R3 R4 R5 R6 table walk; entries with RISE hit the release-at-terminal case
    for (int i = 0; i < NV; i++) run_strobe(VEC[i][0], VEC[i][1]);

    // R7: reset in the middle of a stretch, strobe still low
    @(negedge clk);
    strobe_n = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 0;
    #1 check("R7", ready, 1'b0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    for (int k = 1; k <= RISE + 2; k++) begin
      @(posedge clk);
      #2 check("R7", ready, k >= RISE);
    end
    @(negedge clk);
    strobe_n = 1;
    #1 check("R5", ready, 1'b1);
    repeat (3) @(posedge clk);

    // R6: full delay after the reset-interrupted stretch
    run_strobe(RISE + 1, 3);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule